// File: doc/BRIEF.md
# Masked Interrupt Status Register Bank

This block holds the interrupt status word of a memory card host controller, together with its two enable masks. It sits on a 32-bit register bus. Event pulses from elsewhere in the controller set sticky status bits. Software reads the status word and writes ones to acknowledge the events it has handled. An interrupt-enable mask and a signal-enable mask decide which pending bits reach the single level interrupt line. That line is driven from a flop.

The status word also carries a summary error flag at bit 15. It is not stored: it is formed on every status read from the error-class half of the word, bits 31 to 16. Two status bits cannot be cleared through the clear path:

- the card interrupt bit (bit 8);
- the summary flag (bit 15).

The card interrupt bit is instead dropped when software writes the interrupt-enable mask with that bit's enable cleared. The out-of-band enable bit in the interrupt-enable mask only accepts a write while an external control bit allows it.

The implemented status bits are 0, 1, 2, 4, 5, 8, 9, 16 to 22, 24, 28 and 29, with the summary flag at 15. The register offsets are word indices on `bus_addr`:

| `bus_addr` | Register |
|---|---|
| 0 | status |
| 1 | interrupt enable |
| 2 | signal enable |
| 3 | unmapped |

Top module: `isr_bank`

## Requirements
- R1: After reset the status word, both enable masks and `irq` are all zero.
- R2: An event pulse on an implemented status bit (0, 1, 2, 4, 5, 8, 9, 16 to 22, 24, 28, 29) sets that bit from the next clock edge. The bit stays set until it is cleared. Pulses on any other bit position have no effect.
- R3: A bus write to address 0 clears every clearable status bit whose write-data bit is one. Status bits whose write-data bit is zero keep their value.
- R4: In a status write, write-data bits 8 (card interrupt) and 15 (summary) are ignored. The card interrupt bit keeps its value.
- R5: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A read of address 0 returns bit 15 as one exactly when any status bit from 31 down to 16 is set. All other bits are returned as stored.
- R7: `irq` equals the OR over the bitwise AND of status, interrupt enable and signal enable, taken at the previous clock edge. This gives one cycle of latency.
- R8: A write to address 1 or 2 stores only the implemented status bit positions. Bit 15 and the unimplemented positions always read back as zero.
- R9: While `oob_wr_allow` is low, a write to address 1 leaves interrupt-enable bit 9 at its old value. While `oob_wr_allow` is high, bit 9 takes the written value.
- R10: A write to address 1 with write-data bit 8 at zero clears status bit 8, unless an event pulse sets bit 8 in the same cycle.
- R11: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word index: 0 status, 1 interrupt enable, 2 signal enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| oob_wr_allow | input | 1 | Control bit that allows writes to interrupt-enable bit 9 |
| evt_pulse | input | 32 | Event pulses, one per status bit position |
| irq | output | 1 | Registered level interrupt |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both.

- **Event against software clear.** An event pulse can arrive in the same cycle as software's write-one-to-clear on the same bit. The bench aims a pulse and a clear at one bit in a single cycle, and also at distinct bits. A directed case reads the word back afterwards and expects the set to win.
- **Enable write against card interrupt event.** An interrupt-enable write that drops the card interrupt bit can meet a new card interrupt event. The bench provokes this in directed cases and expects the event to survive.

Random cycles mix events, clears, enable writes and toggling of `oob_wr_allow`. After every cycle, a bench model judges all three registers and the delayed interrupt.

// File: rtl/isr_bank_pkg.sv
package isr_bank_pkg;
  localparam int DW = 32;
  // bit positions whose behaviour the block depends on
  localparam int CARD_BIT = 8;
  localparam int OOB_BIT  = 9;
  localparam int SUM_BIT  = 15;
  localparam int ERR_LO   = 16;
  // implemented stored bits: 0,1,2,4,5,8,9,16..22,24,28,29
  localparam logic [DW-1:0] STORE_MASK = 32'h317F_0337;
  // clearable by software: stored bits except card interrupt
  localparam logic [DW-1:0] CLR_MASK   = STORE_MASK & ~(32'h1 << CARD_BIT);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_INT_EN = 2'd1,
    SEL_SIG_EN = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_status_reg.sv
module isr_status_reg
  import isr_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] clr_vec,
  input  logic          card_drop,
  input  logic [DW-1:0] set_vec,
  output logic [DW-1:0] st_q,
  output logic [DW-1:0] st_rd
);
  logic [DW-1:0] drop_vec;
  logic [DW-1:0] st_d;
  logic          err_any;

  always_comb begin
    drop_vec = '0;
    drop_vec[CARD_BIT] = card_drop;
    // clear first, then set, so a simultaneous event is kept
    st_d = ((st_q & ~(clr_vec & CLR_MASK) & ~drop_vec) | set_vec) & STORE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign err_any = |st_q[DW-1:ERR_LO];

  always_comb begin
    st_rd = st_q;
    st_rd[SUM_BIT] = err_any;
  end
endmodule

// File: rtl/isr_enable_reg.sv
module isr_enable_reg
  import isr_bank_pkg::*;
#(
  parameter bit GATE_OOB = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          oob_allow,
  output logic [DW-1:0] en_q
);
  logic [DW-1:0] en_w;

  generate
    if (GATE_OOB) begin : g_gated
      always_comb begin
        en_w = wdata & STORE_MASK;
        if (!oob_allow) en_w[OOB_BIT] = en_q[OOB_BIT];
      end
    end else begin : g_plain
      logic unused_allow;
      assign unused_allow = oob_allow;
      always_comb en_w = wdata & STORE_MASK;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_w;
  end
endmodule

// File: rtl/isr_irq_out.sv
module isr_irq_out
  import isr_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] st,
  input  logic [DW-1:0] int_en,
  input  logic [DW-1:0] sig_en,
  output logic          irq
);
  logic hit;
  assign hit = |(st & int_en & sig_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end
endmodule

// File: rtl/isr_bank.sv
module isr_bank
  import isr_bank_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              oob_wr_allow,
  input  logic [DW-1:0]     evt_pulse,
  output logic              irq
);
  reg_sel_e      sel;
  logic          wr_st, wr_ie, wr_se;
  logic [DW-1:0] st_q, st_rd, ie_q, se_q;
  logic [DW-1:0] clr_vec;
  logic          card_drop;

  always_comb begin
    case (bus_addr)
      ADDR_W'(0): sel = SEL_STATUS;
      ADDR_W'(1): sel = SEL_INT_EN;
      ADDR_W'(2): sel = SEL_SIG_EN;
      default:    sel = SEL_NONE;
    endcase
  end

  assign wr_st     = bus_wr && (sel == SEL_STATUS);
  assign wr_ie     = bus_wr && (sel == SEL_INT_EN);
  assign wr_se     = bus_wr && (sel == SEL_SIG_EN);
  assign clr_vec   = wr_st ? bus_wdata : '0;
  assign card_drop = wr_ie && !bus_wdata[CARD_BIT];

  isr_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_vec  (clr_vec),
    .card_drop(card_drop),
    .set_vec  (evt_pulse),
    .st_q     (st_q),
    .st_rd    (st_rd)
  );

  isr_enable_reg #(.GATE_OOB(1'b1)) u_int_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ie),
    .wdata    (bus_wdata),
    .oob_allow(oob_wr_allow),
    .en_q     (ie_q)
  );

  isr_enable_reg #(.GATE_OOB(1'b0)) u_sig_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_se),
    .wdata    (bus_wdata),
    .oob_allow(1'b1),
    .en_q     (se_q)
  );

  isr_irq_out u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (st_q),
    .int_en(ie_q),
    .sig_en(se_q),
    .irq   (irq)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: bus_rdata = st_rd;
      SEL_INT_EN: bus_rdata = ie_q;
      SEL_SIG_EN: bus_rdata = se_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/isr_bank_chk.sv
module isr_bank_chk
  import isr_bank_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              oob_wr_allow,
  input logic [DW-1:0]     evt_pulse,
  input logic              irq,
  input logic [DW-1:0]     st_q,
  input logic [DW-1:0]     ie_q,
  input logic [DW-1:0]     se_q
);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse & STORE_MASK) != '0) |=>
      ((st_q & $past(evt_pulse & STORE_MASK)) == $past(evt_pulse & STORE_MASK)));

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ie_q & se_q)) |=> irq);

  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_q & ie_q & se_q)) |=> !irq);

  a_r8_no_sum_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(2)) && bus_wdata[SUM_BIT])
      |=> (!ie_q[SUM_BIT] && !se_q[SUM_BIT]));

  a_r9_oob_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && !oob_wr_allow)
      |=> (ie_q[OOB_BIT] == $past(ie_q[OOB_BIT])));

  a_r4_card_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && st_q[CARD_BIT]) |=> st_q[CARD_BIT]);

  a_r10_card_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && !bus_wdata[CARD_BIT] && !evt_pulse[CARD_BIT])
      |=> !st_q[CARD_BIT]);
endmodule

bind isr_bank isr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/isr_bank_bench.sv
module isr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M_STORE = (32'h1 << 0) | (32'h1 << 1) | (32'h1 << 2) |
    (32'h1 << 4) | (32'h1 << 5) | (32'h1 << 8) | (32'h1 << 9) | (32'h7F << 16) |
    (32'h1 << 24) | (32'h1 << 28) | (32'h1 << 29);
  localparam logic [31:0] M_CLR = M_STORE & ~(32'h1 << 8);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        oob_wr_allow = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        irq;

  int vectors = 0;
  int misses = 0;
  logic [31:0] m_st = '0, m_ie = '0, m_se = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_bank u_isr_bank (.*);

  function automatic logic [31:0] exp_status(input logic [31:0] s);
    logic [31:0] r = s;
    r[15] = |s[31:16];
    return r;
  endfunction

  function automatic logic [31:0] next_st(input logic [31:0] s, input logic wr,
      input logic [1:0] a, input logic [31:0] wd, input logic [31:0] ev);
    logic [31:0] r = s;
    if (wr && a == 2'd0) r = r & ~(wd & M_CLR);
    if (wr && a == 2'd1 && !wd[8]) r[8] = 1'b0;
    return (r | ev) & M_STORE;
  endfunction

  function automatic logic [31:0] next_ie(input logic [31:0] e, input logic [31:0] wd,
      input logic oob);
    logic [31:0] r = wd & M_STORE;
    if (!oob) r[9] = e[9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic read_all(input string tag);
    bus_addr = 2'd0; #1; check({tag, " status"}, bus_rdata, exp_status(m_st));
    bus_addr = 2'd1; #1; check({tag, " int-en"}, bus_rdata, m_ie);
    bus_addr = 2'd2; #1; check({tag, " sig-en"}, bus_rdata, m_se);
    bus_addr = 2'd3; #1; check("R11 unmapped", bus_rdata, 32'h0);
  endtask

  task automatic step(input string tag, input logic wr, input logic [1:0] a,
      input logic [31:0] wd, input logic [31:0] ev, input logic oob);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_pulse = ev; oob_wr_allow = oob;
    @(posedge clk);
    m_irq = |(m_st & m_ie & m_se);
    m_st = next_st(m_st, wr, a, wd, ev);
    if (wr && a == 2'd1) m_ie = next_ie(m_ie, wd, oob);
    if (wr && a == 2'd2) m_se = wd & M_STORE;
    #1;
    bus_wr = 1'b0; evt_pulse = '0;
    check({tag, " R7 irq"}, {31'd0, irq}, {31'd0, m_irq});
    read_all(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    read_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    step("R2 set bits 0,16, R6 summary", 1'b0, 2'd0, '0, 32'h0001_0001, 1'b0);
    step("R2 unimplemented pulses", 1'b0, 2'd0, '0, 32'hCE80_C8C8, 1'b0);
    step("R3 clear bit 0", 1'b1, 2'd0, 32'h0000_0001, '0, 1'b0);
    step("R2 set card bit 8", 1'b0, 2'd0, '0, 32'h0000_0102, 1'b0);
    step("R4 write all ones keeps 8", 1'b1, 2'd0, 32'hFFFF_FFFF, '0, 1'b0);
    step("R6 summary cleared", 1'b0, 2'd0, '0, '0, 1'b0);
    step("R5 set beats clear bit 1", 1'b1, 2'd0, 32'h0000_0002, 32'h0000_0002, 1'b0);
    step("R8 R9 int-en gated", 1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b0);
    step("R8 R9 int-en allowed", 1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b1);
    step("R8 sig-en", 1'b1, 2'd2, 32'hFFFF_FFFF, '0, 1'b0);
    step("R7 irq follows", 1'b0, 2'd0, '0, '0, 1'b0);
    step("R3 clear all", 1'b1, 2'd0, 32'hFFFF_FFFF, '0, 1'b0);
    step("R7 irq from bit 8", 1'b0, 2'd0, '0, '0, 1'b0);
    step("R10 drop with event", 1'b1, 2'd1, 32'h0000_0200, 32'h0000_0100, 1'b1);
    step("R10 drop card bit", 1'b1, 2'd1, 32'h0000_0200, '0, 1'b1);
    step("R9 clear oob gated", 1'b1, 2'd1, 32'h0000_0000, '0, 1'b0);
    step("R11 write unmapped", 1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0, 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] ev = (r[2:0] == 3'd0) ? $urandom : (32'h1 << r[7:3]);
      logic        wr = r[8] | r[9];
      logic [1:0]  a  = r[11:10];
      logic [31:0] wd = r[12] ? ($urandom | (32'h1 << r[17:13])) : (32'h1 << r[17:13]);
      if (r[20]) ev = '0;
      if (r[21] && wr && a == 2'd0) ev = ev | wd;  // same-cycle set and clear
      step("R2/R3/R5/R7/R9/R10 random", wr, a, wd, ev, r[22]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule